// File: doc/BRIEF.md
# Top-Two-Energy Candidate Frame Packer

The block collects, once per bunch crossing, the results of sixteen candidate positions. Each position reports whether it holds a candidate, eight threshold bits, an 8-bit transverse energy, a 5-bit fine position and a 3-bit isolation code. From these it builds one 96-bit frame with three parts. The first part is a 16-bit occupancy map. The second is a list of threshold bytes for the first six occupied positions. The third is a pair of rich records for the two candidates with the largest energy.

The frame leaves on 24 parallel lines over four fast ticks, lowest bits first. One crossing lasts four fast ticks, and a strobe marks the tick on which the candidate inputs are valid. The energy selection runs in two register stages, made of group winners and then a final merge, so the first word appears two ticks after the capture edge.

Top module: `top2_frame_packer`

## Requirements
- R1: After reset, `frame_word` is zero, and `frame_vld` and `frame_first` are low until a captured crossing reaches the output.
- R2: Frame bits [15:0] are the occupancy map: bit i equals `roi_valid[i]` as captured.
- R3: Frame bits [63:16] hold six threshold slots, slot k at bits [16+8k +: 8]. Slot k carries the thresholds of the (k+1)-th occupied position in ascending index order. Slots past the number of occupied positions are zero, and positions beyond the sixth occupied one appear only in the map.
- R4: Frame bits [79:64] hold the record of the highest-energy candidate and bits [95:80] the record of the runner-up. Each record is energy in bits [7:0], fine position in [12:8] and isolation in [15:13].
- R5: When energies are equal, the candidate with the lower position index ranks higher.
- R6: Only positions that are occupied and have nonzero energy compete for the records. A record with no competitor is all zero, so a nonzero energy field marks a present record.
- R7: Inputs are captured on the clock edge where `bc_start` is high. Word 0 is on the lines after the second following edge, with `frame_first` high for that tick only. `frame_vld` is high for exactly the four ticks of the frame.
- R8: Word k on `frame_word` carries frame bits [24k+23 : 24k].
- R9: Strobes every four ticks produce frames back to back with no idle tick between them, each frame formed from its own crossing.
- R10: While `frame_vld` is low, `frame_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock, four ticks per crossing |
| rst | input | 1 | Synchronous active-high reset |
| bc_start | input | 1 | Capture strobe for the candidate inputs |
| roi_valid | input | 16 | Occupancy flag per position |
| roi_thr | input | 128 | Threshold byte per position, position i at [8i +: 8] |
| roi_et | input | 128 | Energy per position, position i at [8i +: 8] |
| roi_loc | input | 80 | Fine position per position, position i at [5i +: 5] |
| roi_iso | input | 48 | Isolation code per position, position i at [3i +: 3] |
| frame_word | output | 24 | Current 24-line frame word |
| frame_vld | output | 1 | High during the four words of a frame |
| frame_first | output | 1 | High with word 0 of a frame |

## Verification
A few scattered candidates with distinct energies check the map, the compaction of the threshold list and the order of the two records. A fully occupied crossing shows the cut after six threshold slots, and places the winners in different selection groups, so the merge stage is exercised as well as the group stage. Equal energies at several positions tell the index tie-break apart from the arrival order. Further patterns cover an empty crossing, a single candidate, occupied zero-energy positions and unoccupied high-energy positions; these separate proper exclusion from stale or leaked records. Two strobes four ticks apart show that consecutive frames stay distinct.

// File: rtl/roi_pack_pkg.sv
package roi_pack_pkg;
    localparam int NUM_ROI   = 16;
    localparam int IDX_W     = $clog2(NUM_ROI);
    localparam int THR_W     = 8;
    localparam int ET_W      = 8;
    localparam int LOC_W     = 5;
    localparam int ISO_W     = 3;
    localparam int HIT_SLOTS = 6;
    localparam int LINES     = 24;
    localparam int TICKS     = 4;
    localparam int GROUPS    = 4;
    localparam int GRP_SIZE  = NUM_ROI / GROUPS;
    localparam int REC_W     = ET_W + LOC_W + ISO_W;
    localparam int FRAME_W   = LINES * TICKS;
    localparam int LEFT_W    = $clog2(TICKS + 1);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [ET_W-1:0]  et;
        logic [LOC_W-1:0] loc;
        logic [ISO_W-1:0] iso;
    } cand_t;

    // a outranks b: larger energy, or equal energy at a lower index
    function automatic logic beats(cand_t a, cand_t b);
        return a.vld && (!b.vld || (a.et > b.et) ||
                         ((a.et == b.et) && (a.idx < b.idx)));
    endfunction

    function automatic logic [REC_W-1:0] to_record(cand_t c);
        return c.vld ? {c.iso, c.loc, c.et} : '0;
    endfunction
endpackage

// File: rtl/roi_top2_pick.sv
module roi_top2_pick
    import roi_pack_pkg::*;
#(
    parameter int N = 4
) (
    input  cand_t [N-1:0] cands,
    output cand_t         first,
    output cand_t         second
);
    always_comb begin
        first  = '0;
        second = '0;
        for (int i = 0; i < N; i++) begin
            if (beats(cands[i], first)) begin
                second = first;
                first  = cands[i];
            end else if (beats(cands[i], second)) begin
                second = cands[i];
            end
        end
    end
endmodule

// File: rtl/roi_hit_list.sv
module roi_hit_list
    import roi_pack_pkg::*;
(
    input  logic [NUM_ROI-1:0]         valid,
    input  logic [NUM_ROI*THR_W-1:0]   thr,
    output logic [HIT_SLOTS*THR_W-1:0] hits
);
    always_comb begin
        int n;
        n    = 0;
        hits = '0;
        for (int i = 0; i < NUM_ROI; i++) begin
            if (valid[i] && (n < HIT_SLOTS)) begin
                hits[n*THR_W +: THR_W] = thr[i*THR_W +: THR_W];
                n++;
            end
        end
    end
endmodule

// File: rtl/top2_frame_packer.sv
module top2_frame_packer
    import roi_pack_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bc_start,
    input  logic [NUM_ROI-1:0]         roi_valid,
    input  logic [NUM_ROI*THR_W-1:0]   roi_thr,
    input  logic [NUM_ROI*ET_W-1:0]    roi_et,
    input  logic [NUM_ROI*LOC_W-1:0]   roi_loc,
    input  logic [NUM_ROI*ISO_W-1:0]   roi_iso,
    output logic [LINES-1:0]           frame_word,
    output logic                       frame_vld,
    output logic                       frame_first
);
    typedef struct packed {
        logic                       cap_go;
        logic [NUM_ROI-1:0]         cap_vld;
        logic [NUM_ROI*THR_W-1:0]   cap_thr;
        logic [NUM_ROI*ET_W-1:0]    cap_et;
        logic [NUM_ROI*LOC_W-1:0]   cap_loc;
        logic [NUM_ROI*ISO_W-1:0]   cap_iso;
        logic                       s1_go;
        logic [NUM_ROI-1:0]         s1_map;
        logic [HIT_SLOTS*THR_W-1:0] s1_hits;
        cand_t [2*GROUPS-1:0]       s1_best;
        logic [FRAME_W-1:0]         sh;
        logic [LEFT_W-1:0]          left;
        logic                       first;
    } state_t;

    state_t state_d, state_q;

    cand_t [NUM_ROI-1:0]         cands_c;
    cand_t [2*GROUPS-1:0]        grp_top;
    cand_t                       top_a, top_b;
    logic [HIT_SLOTS*THR_W-1:0]  hits_c;
    logic [FRAME_W-1:0]          frame_c;

    // candidate view of the captured crossing
    always_comb begin
        for (int i = 0; i < NUM_ROI; i++) begin
            cands_c[i].vld = state_q.cap_vld[i] && (state_q.cap_et[i*ET_W +: ET_W] != '0);
            cands_c[i].idx = IDX_W'(i);
            cands_c[i].et  = state_q.cap_et[i*ET_W +: ET_W];
            cands_c[i].loc = state_q.cap_loc[i*LOC_W +: LOC_W];
            cands_c[i].iso = state_q.cap_iso[i*ISO_W +: ISO_W];
        end
    end

    // stage one: best two inside each group
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        roi_top2_pick #(.N(GRP_SIZE)) u_grp (
            .cands  (cands_c[g*GRP_SIZE +: GRP_SIZE]),
            .first  (grp_top[2*g]),
            .second (grp_top[2*g+1])
        );
    end

    roi_hit_list u_hits (
        .valid (state_q.cap_vld),
        .thr   (state_q.cap_thr),
        .hits  (hits_c)
    );

    // stage two: merge of the group winners
    roi_top2_pick #(.N(2*GROUPS)) u_merge (
        .cands  (state_q.s1_best),
        .first  (top_a),
        .second (top_b)
    );

    assign frame_c = {to_record(top_b), to_record(top_a), state_q.s1_hits, state_q.s1_map};

    always_comb begin
        state_d        = state_q;
        state_d.cap_go = bc_start;
        if (bc_start) begin
            state_d.cap_vld = roi_valid;
            state_d.cap_thr = roi_thr;
            state_d.cap_et  = roi_et;
            state_d.cap_loc = roi_loc;
            state_d.cap_iso = roi_iso;
        end
        state_d.s1_go = state_q.cap_go;
        if (state_q.cap_go) begin
            state_d.s1_map  = state_q.cap_vld;
            state_d.s1_hits = hits_c;
            state_d.s1_best = grp_top;
        end
        state_d.first = 1'b0;
        if (state_q.s1_go) begin
            state_d.sh    = frame_c;
            state_d.left  = LEFT_W'(TICKS);
            state_d.first = 1'b1;
        end else if (state_q.left != '0) begin
            state_d.sh   = state_q.sh >> LINES;
            state_d.left = state_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign frame_word  = state_q.sh[LINES-1:0];
    assign frame_vld   = (state_q.left != '0);
    assign frame_first = state_q.first;
endmodule

// File: rtl/top2_frame_packer_chk.sv
module top2_frame_packer_chk #(
    parameter int LINES = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bc_start,
    input logic [LINES-1:0] frame_word,
    input logic             frame_vld,
    input logic             frame_first
);
    logic       start_d1, start_d2, start_d3;
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_d1 <= 1'b0;
            start_d2 <= 1'b0;
            start_d3 <= 1'b0;
            run_q    <= '0;
        end else begin
            start_d1 <= bc_start;
            start_d2 <= start_d1;
            start_d3 <= start_d2;
            if (frame_first)    run_q <= 3'd1;
            else if (frame_vld) run_q <= run_q + 3'd1;
            else                run_q <= '0;
        end
    end

    AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_d2 |=> frame_first); // R7
    AST_FIRST_HAS_START: assert property (@(posedge clk) disable iff (rst)
        frame_first |-> start_d3); // R7
    AST_FIRST_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        frame_first |-> frame_vld); // R7
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !frame_first) |-> (run_q >= 3'd1 && run_q <= 3'd3)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |-> (frame_word == '0)); // R10
endmodule

bind top2_frame_packer top2_frame_packer_chk #(.LINES(24)) u_chk (.*);

// File: tb/top2_frame_packer_tb.sv
module top2_frame_packer_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bc_start = 1'b0;
    logic [15:0]  roi_valid = '0;
    logic [127:0] roi_thr = '0;
    logic [127:0] roi_et = '0;
    logic [79:0]  roi_loc = '0;
    logic [47:0]  roi_iso = '0;
    logic [23:0]  frame_word;
    logic         frame_vld, frame_first;

    logic [15:0]  s_v   [2];
    logic [127:0] s_thr [2];
    logic [127:0] s_et  [2];
    logic [79:0]  s_loc [2];
    logic [47:0]  s_iso [2];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    top2_frame_packer u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int f = 0; f < 2; f++) begin
            s_v[f] = '0; s_thr[f] = '0; s_et[f] = '0; s_loc[f] = '0; s_iso[f] = '0;
        end
    endtask

    task automatic set_roi(input int f, input int i, input logic [7:0] t, input logic [7:0] e,
                           input logic [4:0] l, input logic [2:0] s);
        s_v[f][i]         = 1'b1;
        s_thr[f][i*8 +: 8] = t;
        s_et[f][i*8 +: 8]  = e;
        s_loc[f][i*5 +: 5] = l;
        s_iso[f][i*3 +: 3] = s;
    endtask

    // expected frame computed from the requirements
    function automatic logic [95:0] model(input int f);
        logic [95:0] fr;
        int n, b1, b2;
        fr = '0;
        fr[15:0] = s_v[f];                                   // R2
        n = 0;
        for (int i = 0; i < 16; i++)
            if (s_v[f][i] && n < 6) begin                    // R3
                fr[16 + 8*n +: 8] = s_thr[f][i*8 +: 8];
                n++;
            end
        b1 = -1; b2 = -1;
        for (int i = 0; i < 16; i++)                         // R5 strict compare keeps lower index
            if (s_v[f][i] && s_et[f][i*8 +: 8] != 0 &&
                (b1 < 0 || s_et[f][i*8 +: 8] > s_et[f][b1*8 +: 8])) b1 = i;
        for (int i = 0; i < 16; i++)
            if (i != b1 && s_v[f][i] && s_et[f][i*8 +: 8] != 0 &&
                (b2 < 0 || s_et[f][i*8 +: 8] > s_et[f][b2*8 +: 8])) b2 = i;
        if (b1 >= 0) fr[79:64] = {s_iso[f][b1*3 +: 3], s_loc[f][b1*5 +: 5], s_et[f][b1*8 +: 8]}; // R4
        if (b2 >= 0) fr[95:80] = {s_iso[f][b2*3 +: 3], s_loc[f][b2*5 +: 5], s_et[f][b2*8 +: 8]};
        return fr;
    endfunction

    // drives nfr crossings four ticks apart and checks every output tick
    task automatic play(input int nfr, input string req);
        logic [95:0] exp [2];
        for (int f = 0; f < nfr; f++) exp[f] = model(f);
        for (int t = 0; t < 4*nfr + 6; t++) begin
            if (t >= 3 && (t - 3) / 4 < nfr) begin
                int f, k;
                f = (t - 3) / 4;
                k = (t - 3) % 4;
                check(frame_vld === 1'b1 && frame_first === (k == 0), "R7", {frame_vld, frame_first}, {1'b1, k == 0});
                check(frame_word === exp[f][24*k +: 24], req, frame_word, exp[f][24*k +: 24]); // R8
            end else begin
                check(frame_vld === 1'b0 && frame_word === '0, "R10", {frame_vld, frame_word}, 0);
            end
            if (t % 4 == 0 && t / 4 < nfr) begin
                bc_start  = 1'b1;
                roi_valid = s_v[t/4]; roi_thr = s_thr[t/4]; roi_et = s_et[t/4];
                roi_loc   = s_loc[t/4]; roi_iso = s_iso[t/4];
            end else begin
                bc_start  = 1'b0;
                roi_valid = '1; roi_thr = '1; roi_et = '1; roi_loc = '1; roi_iso = '1;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(frame_vld === 1'b0 && frame_first === 1'b0 && frame_word === '0, "R1",
              {frame_vld, frame_first, frame_word}, 0);
    endtask

    task automatic t_scattered();
        clear_stim();
        set_roi(0, 2, 8'h11, 8'd40, 5'd3, 3'd1);
        set_roi(0, 7, 8'h22, 8'd90, 5'd17, 3'd5);
        set_roi(0, 13, 8'h33, 8'd60, 5'd30, 3'd7);
        play(1, "R2 R3 R4 R8");
    endtask

    task automatic t_full();
        clear_stim();
        for (int i = 0; i < 16; i++)
            set_roi(0, i, 8'(8'hA0 + i), 8'(10 + 7*i), 5'(i), 3'(i));
        set_roi(0, 0, 8'hC3, 8'd200, 5'd9, 3'd6);            // winner in group 0, runner-up at 15
        play(1, "R3 R4 overflow");
    endtask

    task automatic t_ties();
        clear_stim();
        set_roi(0, 12, 8'h01, 8'd77, 5'd1, 3'd1);
        set_roi(0, 9, 8'h02, 8'd77, 5'd2, 3'd2);
        set_roi(0, 3, 8'h03, 8'd77, 5'd3, 3'd3);
        set_roi(0, 5, 8'h04, 8'd20, 5'd4, 3'd4);
        play(1, "R5");
    endtask

    task automatic t_sparse();
        clear_stim();
        play(1, "R6 empty");
        clear_stim();
        set_roi(0, 10, 8'h5A, 8'd1, 5'd31, 3'd7);
        play(1, "R6 single");
    endtask

    task automatic t_excluded();
        clear_stim();
        set_roi(0, 1, 8'h10, 8'd0, 5'd8, 3'd2);               // occupied, zero energy
        set_roi(0, 6, 8'h20, 8'd15, 5'd12, 3'd3);
        s_et[0][4*8 +: 8] = 8'd250;                           // unoccupied, large energy
        s_loc[0][4*5 +: 5] = 5'd20;
        play(1, "R6 exclusion");
    endtask

    task automatic t_back_to_back();
        clear_stim();
        set_roi(0, 0, 8'hE1, 8'd33, 5'd5, 3'd2);
        set_roi(0, 8, 8'hE2, 8'd44, 5'd6, 3'd3);
        set_roi(1, 15, 8'hF1, 8'd99, 5'd7, 3'd4);
        set_roi(1, 4, 8'hF2, 8'd98, 5'd10, 3'd5);
        set_roi(1, 11, 8'hF3, 8'd12, 5'd11, 3'd6);
        play(2, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_scattered();
        t_full();
        t_ties();
        t_sparse();
        t_excluded();
        t_back_to_back();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule